// File: doc/BRIEF.md
# Audio Bus Command Queue Engine

This block sits between software and the command port of a two-wire audio bus controller. Software posts 32-bit command words through two register slots, one for writes and one for reads. Each word carries a peripheral register address, a four-bit tag, a device number and either one data byte or a read length. The engine keeps the words in a small queue and hands them to the bus command port one at a time, in the order they arrived. If the peripheral answers with a nak, the engine sends the same command again, up to a programmable limit.

Bytes returned by read commands are collected in a byte queue. Software drains that queue one word per read, with the byte in the low eight bits. Two single-cycle event outputs feed an interrupt unit. One marks the successful completion of a command whose tag is all ones. The other marks a command that kept failing after every retry. A status word reports queue fill levels, a sticky overflow flag and whether the engine is busy. A control write empties the command queue when software needs to recover after an error.

Top module: `cmdq_engine`

## Requirements
- R1: A command word is presented on `cmdWord` exactly as software wrote it. Bits 15:0 hold the register address, 19:16 the tag, 23:20 the device number, and 31:24 the data byte or read length.
- R2: A write to offset 0x300 queues a write command (`cmdIsRead`=0) and a write to 0x304 queues a read command (`cmdIsRead`=1). Commands are issued strictly in arrival order.
- R3: The command queue holds CMD_DEPTH (8) entries. A command write to a full queue is dropped, and the sticky overflow flag (status bit 8) is set.
- R4: The status register at 0x30C reads bits 7:0 as the command queue count, bit 8 as overflow, bit 9 as busy (a command is in flight) and bits 23:16 as the read byte count. After reset the status reads 0 and the retry limit at 0x314 reads 7.
- R5: While `cmdValid` is high and `cmdReady` is low, `cmdValid`, `cmdWord` and `cmdIsRead` hold steady. The only exception is a flush.
- R6: A nak response reissues the command. The retry limit at 0x314 sets how many reissues are allowed. After limit+1 naks, `evtCmdError` pulses for one cycle, the command is discarded, and the next queued command is issued.
- R7: A read acked with length N accepts N bytes on `rdByteValid` and pushes them into the read queue. It completes on the last byte. A length above 15 is treated as 15, and a length of 0 completes at the ack.
- R8: A read at 0x318 pops the oldest byte and returns it zero-extended in bits 7:0. A read of an empty queue returns 0.
- R9: `evtSpecialDone` pulses for one cycle, in the cycle after a command with tag 0xF completes successfully. Commands with any other tag never raise it, and it never coincides with `evtCmdError`.
- R10: Writing 1 in bit 0 at 0x308 empties the command queue, clears overflow and abandons the command in flight, so `cmdValid` is low on the next cycle. A write with bit 0 clear has no effect.
- R11: A read command is not issued until the read queue has free space for its whole (clamped) length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops at 0x318) |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid while regRdEn is high |
| cmdValid | output | 1 | Command offered to the bus port |
| cmdReady | input | 1 | Bus port accepts the command |
| cmdWord | output | 32 | Packed command word |
| cmdIsRead | output | 1 | Offered command is a read |
| rspValid | input | 1 | Peripheral response present |
| rspAck | input | 1 | 1 = ack, 0 = nak |
| rdByteValid | input | 1 | Returned read byte present |
| rdByte | input | 8 | Returned read byte |
| evtSpecialDone | output | 1 | Pulse: tag-0xF command completed |
| evtCmdError | output | 1 | Pulse: command failed after all retries |

## Verification
The bench builds the engine with CMD_DEPTH=8 and RD_DEPTH=16. With an 8-entry queue, a ninth post reaches the overflow case within a few cycles. With a 16-byte read queue, one clamped 15-byte read leaves a single free slot, so a two-byte read becomes stalled by the room check. Setting the retry limit to 2 keeps the exhaustion path short enough to watch every reissue.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFF_WR_CMD = 12'h300;
  localparam logic [REG_AW-1:0] OFF_RD_CMD = 12'h304;
  localparam logic [REG_AW-1:0] OFF_CTRL   = 12'h308;
  localparam logic [REG_AW-1:0] OFF_STATUS = 12'h30C;
  localparam logic [REG_AW-1:0] OFF_RETRY  = 12'h314;
  localparam logic [REG_AW-1:0] OFF_RDPOP  = 12'h318;

  localparam int ST_OVF_BIT   = 8;
  localparam int ST_BUSY_BIT  = 9;
  localparam int ST_RDCNT_LSB = 16;

  localparam int MAX_RD_LEN = 15;
  localparam int LEN_W      = 4;
  localparam logic [3:0] SPECIAL_TAG = 4'hF;

  // queued entry: {isRead, word}
  localparam int ENTRY_W = 33;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RECV} eng_state_t;

  typedef struct packed {
    logic popCmd;
    logic pushRd;
  } dp_strobe_t;
endpackage

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int CMD_DEPTH = 8,
  parameter int RD_DEPTH  = 16,
  parameter int RETRY_W   = 4,
  parameter int RETRY_RST = 7,
  localparam int CPTR_W = $clog2(CMD_DEPTH),
  localparam int CCNT_W = $clog2(CMD_DEPTH + 1),
  localparam int RPTR_W = $clog2(RD_DEPTH),
  localparam int RCNT_W = $clog2(RD_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  dp_strobe_t         strobe,
  input  logic               engineBusy,
  input  logic [7:0]         rdByte,
  output logic [31:0]        headWord,
  output logic               headIsRead,
  output logic               cmdEmpty,
  output logic [RCNT_W-1:0]  rdFree,
  output logic [RETRY_W-1:0] retryLimit,
  output logic               flushReq
);
  logic [ENTRY_W-1:0] cmdMem [CMD_DEPTH];
  logic [CPTR_W-1:0]  cmdWrPtr, cmdRdPtr;
  logic [CCNT_W-1:0]  cmdCount;
  logic               ovfSticky;

  logic [7:0]         rdMem [RD_DEPTH];
  logic [RPTR_W-1:0]  rdWrPtr, rdRdPtr;
  logic [RCNT_W-1:0]  rdCount;

  logic cmdPost, cmdFull, cmdPush, cmdPop;
  logic rdPush, rdPop, rdEmpty;

  assign cmdPost  = regWrEn && (regAddr == OFF_WR_CMD || regAddr == OFF_RD_CMD);
  assign flushReq = regWrEn && regAddr == OFF_CTRL && regWrData[0];
  assign cmdFull  = cmdCount == CCNT_W'(CMD_DEPTH);
  assign cmdEmpty = cmdCount == '0;
  assign cmdPush  = cmdPost && !cmdFull && !flushReq;
  assign cmdPop   = strobe.popCmd && !cmdEmpty && !flushReq;

  assign rdEmpty = rdCount == '0;
  assign rdPush  = strobe.pushRd && rdCount != RCNT_W'(RD_DEPTH);
  assign rdPop   = regRdEn && regAddr == OFF_RDPOP && !rdEmpty;
  assign rdFree  = RCNT_W'(RD_DEPTH) - rdCount;

  assign {headIsRead, headWord} = cmdMem[cmdRdPtr];

  always_ff @(posedge clk) begin
    if (cmdPush) cmdMem[cmdWrPtr] <= {regAddr == OFF_RD_CMD, regWrData};
    if (rdPush)  rdMem[rdWrPtr]   <= rdByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWrPtr  <= '0;
      cmdRdPtr  <= '0;
      cmdCount  <= '0;
      ovfSticky <= 1'b0;
    end else if (flushReq) begin
      cmdWrPtr  <= '0;
      cmdRdPtr  <= '0;
      cmdCount  <= '0;
      ovfSticky <= 1'b0;
    end else begin
      if (cmdPost && cmdFull) ovfSticky <= 1'b1;
      if (cmdPush)
        cmdWrPtr <= (cmdWrPtr == CPTR_W'(CMD_DEPTH - 1)) ? '0 : cmdWrPtr + 1'b1;
      if (cmdPop)
        cmdRdPtr <= (cmdRdPtr == CPTR_W'(CMD_DEPTH - 1)) ? '0 : cmdRdPtr + 1'b1;
      cmdCount <= cmdCount + CCNT_W'(cmdPush) - CCNT_W'(cmdPop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWrPtr <= '0;
      rdRdPtr <= '0;
      rdCount <= '0;
    end else begin
      if (rdPush)
        rdWrPtr <= (rdWrPtr == RPTR_W'(RD_DEPTH - 1)) ? '0 : rdWrPtr + 1'b1;
      if (rdPop)
        rdRdPtr <= (rdRdPtr == RPTR_W'(RD_DEPTH - 1)) ? '0 : rdRdPtr + 1'b1;
      rdCount <= rdCount + RCNT_W'(rdPush) - RCNT_W'(rdPop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) retryLimit <= RETRY_W'(RETRY_RST);
    else if (regWrEn && regAddr == OFF_RETRY) retryLimit <= regWrData[RETRY_W-1:0];
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        OFF_STATUS: begin
          regRdData[7:0]                        = 8'(cmdCount);
          regRdData[ST_OVF_BIT]                 = ovfSticky;
          regRdData[ST_BUSY_BIT]                = engineBusy;
          regRdData[ST_RDCNT_LSB +: 8]          = 8'(rdCount);
        end
        OFF_RETRY: regRdData = 32'(retryLimit);
        OFF_RDPOP: if (!rdEmpty) regRdData = {24'b0, rdMem[rdRdPtr]};
        default:   regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_control.sv
module cmdq_control
  import cmdq_pkg::*;
#(
  parameter int RETRY_W = 4,
  parameter int RCNT_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushReq,
  input  logic               cmdEmpty,
  input  logic               headIsRead,
  input  logic [7:0]         headLenRaw,
  input  logic [3:0]         headTag,
  input  logic [RCNT_W-1:0]  rdFree,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic               cmdReady,
  input  logic               rspValid,
  input  logic               rspAck,
  input  logic               rdByteValid,
  output dp_strobe_t         strobe,
  output logic               cmdValid,
  output logic               busy,
  output logic               evtSpecialDone,
  output logic               evtCmdError
);
  eng_state_t         state, nxtState;
  logic [RETRY_W-1:0] tries;
  logic [LEN_W-1:0]   byteCnt, headLen;
  logic               canIssue, doneOk, failFinal, retryNow;

  assign headLen  = (headLenRaw > 8'(MAX_RD_LEN)) ? LEN_W'(MAX_RD_LEN) : headLenRaw[LEN_W-1:0];
  assign canIssue = !cmdEmpty && (!headIsRead || rdFree >= RCNT_W'(headLen));
  assign cmdValid = state == ST_ISSUE;
  assign busy     = state != ST_IDLE;

  always_comb begin
    nxtState  = state;
    strobe    = '0;
    doneOk    = 1'b0;
    failFinal = 1'b0;
    retryNow  = 1'b0;
    case (state)
      ST_IDLE:  if (canIssue) nxtState = ST_ISSUE;
      ST_ISSUE: if (cmdReady) nxtState = ST_WAIT;
      ST_WAIT: begin
        if (rspValid) begin
          if (rspAck) begin
            if (headIsRead && headLen != '0) nxtState = ST_RECV;
            else doneOk = 1'b1;
          end else if (tries >= retryLimit) begin
            failFinal = 1'b1;
          end else begin
            retryNow = 1'b1;
            nxtState = ST_ISSUE;
          end
        end
      end
      ST_RECV: begin
        if (rdByteValid) begin
          strobe.pushRd = 1'b1;
          if (byteCnt == headLen - 1'b1) doneOk = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
    if (doneOk || failFinal) begin
      strobe.popCmd = 1'b1;
      nxtState      = ST_IDLE;
    end
    if (flushReq) begin
      nxtState  = ST_IDLE;
      strobe    = '0;
      doneOk    = 1'b0;
      failFinal = 1'b0;
      retryNow  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      tries          <= '0;
      byteCnt        <= '0;
      evtSpecialDone <= 1'b0;
      evtCmdError    <= 1'b0;
    end else begin
      state          <= nxtState;
      evtSpecialDone <= doneOk && headTag == SPECIAL_TAG;
      evtCmdError    <= failFinal;
      if (state == ST_IDLE) tries <= '0;
      else if (retryNow) tries <= tries + 1'b1;
      if (state != ST_RECV) byteCnt <= '0;
      else if (strobe.pushRd) byteCnt <= byteCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int CMD_DEPTH = 8,
  parameter int RD_DEPTH  = 16,
  parameter int RETRY_W   = 4,
  parameter int RETRY_RST = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        cmdValid,
  input  logic        cmdReady,
  output logic [31:0] cmdWord,
  output logic        cmdIsRead,
  input  logic        rspValid,
  input  logic        rspAck,
  input  logic        rdByteValid,
  input  logic [7:0]  rdByte,
  output logic        evtSpecialDone,
  output logic        evtCmdError
);
  localparam int RCNT_W = $clog2(RD_DEPTH + 1);

  dp_strobe_t         strobe;
  logic               busy, cmdEmpty, flushReq;
  logic [RCNT_W-1:0]  rdFree;
  logic [RETRY_W-1:0] retryLimit;

  cmdq_datapath #(
    .CMD_DEPTH(CMD_DEPTH), .RD_DEPTH(RD_DEPTH),
    .RETRY_W(RETRY_W), .RETRY_RST(RETRY_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .engineBusy(busy), .rdByte(rdByte),
    .headWord(cmdWord), .headIsRead(cmdIsRead), .cmdEmpty(cmdEmpty),
    .rdFree(rdFree), .retryLimit(retryLimit), .flushReq(flushReq)
  );

  cmdq_control #(.RETRY_W(RETRY_W), .RCNT_W(RCNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .cmdEmpty(cmdEmpty),
    .headIsRead(cmdIsRead), .headLenRaw(cmdWord[31:24]), .headTag(cmdWord[19:16]),
    .rdFree(rdFree), .retryLimit(retryLimit),
    .cmdReady(cmdReady), .rspValid(rspValid), .rspAck(rspAck),
    .rdByteValid(rdByteValid), .strobe(strobe), .cmdValid(cmdValid),
    .busy(busy), .evtSpecialDone(evtSpecialDone), .evtCmdError(evtCmdError)
  );
endmodule

// File: rtl/cmdq_engine_checker.sv
module cmdq_engine_checker
  import cmdq_pkg::*;
#(
  parameter int CMD_DEPTH = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [11:0] regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [31:0] cmdWord,
  input logic        cmdIsRead,
  input logic        rspValid,
  input logic        rspAck,
  input logic        rdByteValid,
  input logic        evtSpecialDone,
  input logic        evtCmdError
);
  logic flushNow;
  assign flushNow = regWrEn && regAddr == OFF_CTRL && regWrData[0];

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady && !flushNow |=> cmdValid && $stable(cmdWord) && $stable(cmdIsRead)); // R5

  AST_ERR_AFTER_NAK: assert property (@(posedge clk) disable iff (!rstN)
    evtCmdError |-> $past(rspValid && !rspAck)); // R6

  AST_SPECIAL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    evtSpecialDone |-> $past((rspValid && rspAck) || rdByteValid)); // R9

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(evtSpecialDone && evtCmdError)); // R9

  AST_FLUSH_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> !cmdValid); // R10

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && regAddr == OFF_STATUS |-> regRdData[7:0] <= 8'(CMD_DEPTH)); // R3
endmodule

bind cmdq_engine cmdq_engine_checker #(.CMD_DEPTH(CMD_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord),
  .cmdIsRead(cmdIsRead), .rspValid(rspValid), .rspAck(rspAck),
  .rdByteValid(rdByteValid), .evtSpecialDone(evtSpecialDone),
  .evtCmdError(evtCmdError)
);

// File: tb/cmdq_engine_bench.sv
module cmdq_engine_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic cmdValid, cmdIsRead, evtSpecialDone, evtCmdError;
  logic [31:0] cmdWord;
  logic cmdReady = 1'b0, rspValid = 1'b0, rspAck = 1'b0, rdByteValid = 1'b0;
  logic [7:0] rdByte = '0;

  int tests = 0;
  int fails = 0;
  logic [32:0] expQ[$];

  always #10 clk = ~clk;

  cmdq_engine #(.CMD_DEPTH(8), .RD_DEPTH(16)) u_cmdq_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord),
    .cmdIsRead(cmdIsRead), .rspValid(rspValid), .rspAck(rspAck),
    .rdByteValid(rdByteValid), .rdByte(rdByte),
    .evtSpecialDone(evtSpecialDone), .evtCmdError(evtCmdError)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model comparison every cycle: offered command equals model head (R2)
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) check(1'b0, "R2 offer with empty model", cmdWord, 32'h0);
      else check({cmdIsRead, cmdWord} == expQ[0], "R2 offered head", cmdWord, expQ[0][31:0]);
    end
  end

  function automatic logic [31:0] mkWord(input logic [7:0] len, input logic [3:0] dev,
                                         input logic [3:0] tag, input logic [15:0] addr);
    return {len, dev, tag, addr};
  endfunction

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 12'h300 || a == 12'h304) begin
      if (expQ.size() < 8) expQ.push_back({a == 12'h304, d});
    end
    if (a == 12'h308 && d[0]) expQ.delete();
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic handshake(input logic [32:0] exp, input string req);
    int guard = 0;
    while (!cmdValid && guard < 200) begin @(negedge clk); guard++; end
    check(cmdValid && {cmdIsRead, cmdWord} == exp, req, cmdWord, exp[31:0]);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic respond(input bit ack);
    rspValid = 1'b1; rspAck = ack;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic giveByte(input logic [7:0] b);
    rdByteValid = 1'b1; rdByte = b;
    @(negedge clk);
    rdByteValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4 reset state
    regRead(12'h30C, d); check(d == 32'h0, "R4 status after reset", d, 32'h0);
    regRead(12'h314, d); check(d == 32'h7, "R4 retry reset", d, 32'h7);

    // R1 plain write command, tag 3: no special event (R9)
    w = mkWord(8'hA5, 4'h2, 4'h3, 16'h0040);
    regWrite(12'h300, w);
    handshake({1'b0, w}, "R1 write word fields");
    respond(1'b1);
    check(!evtSpecialDone && !evtCmdError, "R9 no event for tag 3", {30'b0, evtSpecialDone, evtCmdError}, 0);
    void'(expQ.pop_front());
    regRead(12'h30C, d); check(d == 32'h0, "R4 idle after write done", d, 32'h0);

    // R9 special write
    w = mkWord(8'h01, 4'h1, 4'hF, 16'h0100);
    regWrite(12'h300, w);
    handshake({1'b0, w}, "R2 special write offer");
    respond(1'b1);
    check(evtSpecialDone, "R9 special pulse", {31'b0, evtSpecialDone}, 1);
    void'(expQ.pop_front());
    @(negedge clk);
    check(!evtSpecialDone, "R9 pulse one cycle", {31'b0, evtSpecialDone}, 0);

    // R7 read of 3 bytes tag F, with R5 hold check
    w = mkWord(8'd3, 4'h1, 4'hF, 16'h0010);
    regWrite(12'h304, w);
    repeat (3) @(negedge clk);
    check(cmdValid && cmdWord == w, "R5 offer held without ready", cmdWord, w);
    handshake({1'b1, w}, "R2 read offer");
    respond(1'b1);
    check(!evtSpecialDone, "R7 read not done at ack", {31'b0, evtSpecialDone}, 0);
    giveByte(8'h11); giveByte(8'h22);
    check(!evtSpecialDone, "R7 read not done before last byte", {31'b0, evtSpecialDone}, 0);
    giveByte(8'h33);
    check(evtSpecialDone, "R7 read done at last byte", {31'b0, evtSpecialDone}, 1);
    void'(expQ.pop_front());
    regRead(12'h30C, d); check(d == 32'h0003_0000, "R4 read byte count", d, 32'h0003_0000);
    regRead(12'h318, d); check(d == 32'h11, "R8 pop first", d, 32'h11);
    regRead(12'h318, d); check(d == 32'h22, "R8 pop second", d, 32'h22);
    regRead(12'h318, d); check(d == 32'h33, "R8 pop third", d, 32'h33);
    regRead(12'h318, d); check(d == 32'h0, "R8 pop empty", d, 32'h0);

    // R7 zero length read completes at ack
    w = mkWord(8'd0, 4'h3, 4'hF, 16'h0020);
    regWrite(12'h304, w);
    handshake({1'b1, w}, "R2 zero read offer");
    respond(1'b1);
    check(evtSpecialDone, "R7 zero length done at ack", {31'b0, evtSpecialDone}, 1);
    void'(expQ.pop_front());

    // R6 retries with limit 2
    regWrite(12'h314, 32'h2);
    regRead(12'h314, d); check(d == 32'h2, "R6 retry limit readback", d, 32'h2);
    w = mkWord(8'h5A, 4'h4, 4'hF, 16'h0200);
    regWrite(12'h300, w);
    regWrite(12'h300, mkWord(8'h66, 4'h4, 4'h2, 16'h0201));
    handshake({1'b0, w}, "R6 first attempt");
    respond(1'b0);
    check(!evtCmdError, "R6 no error after nak 1", {31'b0, evtCmdError}, 0);
    handshake({1'b0, w}, "R6 reissue 1");
    respond(1'b0);
    check(!evtCmdError, "R6 no error after nak 2", {31'b0, evtCmdError}, 0);
    handshake({1'b0, w}, "R6 reissue 2");
    respond(1'b0);
    check(evtCmdError && !evtSpecialDone, "R6 error after limit+1 naks", {30'b0, evtSpecialDone, evtCmdError}, 1);
    void'(expQ.pop_front());
    handshake(expQ[0], "R6 next command proceeds");
    respond(1'b0);
    handshake({1'b0, mkWord(8'h66, 4'h4, 4'h2, 16'h0201)}, "R6 retry then ack");
    respond(1'b1);
    check(!evtCmdError && !evtSpecialDone, "R6 ack after one nak", {30'b0, evtSpecialDone, evtCmdError}, 0);
    void'(expQ.pop_front());

    // R3 overflow with engine stalled, then R10 flush
    for (int i = 0; i < 9; i++) regWrite(12'h300, mkWord(8'(i), 4'h5, 4'h1, 16'(i)));
    regRead(12'h30C, d); check(d == 32'h0000_0308, "R3 full queue and overflow", d, 32'h0000_0308);
    regWrite(12'h308, 32'h0);
    regRead(12'h30C, d); check(d == 32'h0000_0308, "R10 bit0 clear no effect", d, 32'h0000_0308);
    regWrite(12'h308, 32'h1);
    check(!cmdValid, "R10 no offer after flush", {31'b0, cmdValid}, 0);
    regRead(12'h30C, d); check(d == 32'h0, "R10 flush clears queue", d, 32'h0);

    // R7 clamp: length 0x20 reads 15 bytes
    w = mkWord(8'h20, 4'h6, 4'hF, 16'h0300);
    regWrite(12'h304, w);
    handshake({1'b1, w}, "R7 clamp offer");
    respond(1'b1);
    for (int i = 0; i < 14; i++) giveByte(8'(8'h40 + i));
    check(!evtSpecialDone, "R7 clamp not done at 14", {31'b0, evtSpecialDone}, 0);
    giveByte(8'h4E);
    check(evtSpecialDone, "R7 clamp done at 15", {31'b0, evtSpecialDone}, 1);
    void'(expQ.pop_front());

    // R11 read stalls until room for 2 bytes
    w = mkWord(8'd2, 4'h6, 4'hF, 16'h0400);
    regWrite(12'h304, w);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!cmdValid, "R11 read held for room", {31'b0, cmdValid}, 0);
    end
    regRead(12'h318, d); check(d == 32'h40, "R8 clamp first byte", d, 32'h40);
    handshake({1'b1, w}, "R11 read issued after pop");
    respond(1'b1);
    giveByte(8'hC1); giveByte(8'hC2);
    check(evtSpecialDone, "R11 stalled read completes", {31'b0, evtSpecialDone}, 1);
    void'(expQ.pop_front());
    regRead(12'h30C, d); check(d == 32'h0010_0000, "R4 read queue full count", d, 32'h0010_0000);
    for (int i = 1; i < 15; i++) begin
      regRead(12'h318, d); check(d == 32'(8'h40 + i), "R8 clamp bytes in order", d, 32'(8'h40 + i));
    end
    regRead(12'h318, d); check(d == 32'hC1, "R8 later read byte 1", d, 32'hC1);
    regRead(12'h318, d); check(d == 32'hC2, "R8 later read byte 2", d, 32'hC2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule